// File: doc/BRIEF.md
# Video Display Processor Host-Port Sequencer

This block sits between a simple command interface on the CPU side and the 8-bit host port of a classic tile and sprite video display processor. A single command is taken in on a one-cycle valid pulse. The block turns it into one or two timed byte accesses on the port, each with a mode select, separate active-low write and read strobes, an output enable for the shared data bus and the byte to drive. It can also generate a timed reset pulse for the display processor. Strobe widths, the recovery gap after each access and both reset phase lengths are parameters counted in clock cycles.

A register write and both kinds of address setup each become two control-port bytes. The second byte carries the prefix that tells the display processor which kind of control sequence it is receiving. Data bytes are sent on their own, with the mode select low, and no address is sent again. The display processor advances its own address after every data access. Reads capture the port byte shortly before the read strobe is released and present it on a result output, marked by a one-cycle valid pulse.

Top module: `vdp_host_seq`

## Requirements
- R1: `bus_mode` is 1 during every strobe of a control-port access (command codes 0, 1, 2 and 5) and 0 during every strobe of a data access (codes 3 and 4).
- R2: `bus_wr_n` and `bus_rd_n` are high while idle, and the two are never low in the same cycle.
- R3: Command code 0 (register write) sends `cmd_data` first and then the byte 1000_0RRR, where RRR is `cmd_arg[2:0]`.
- R4: Command codes 1 (write-address setup) and 2 (read-address setup) send `cmd_arg[7:0]` first. The second byte is {2'b01, `cmd_arg[13:8]`} for code 1 and {2'b00, `cmd_arg[13:8]`} for code 2.
- R5: Command code 3 (data write) sends exactly one byte, `cmd_data`, and sends no address bytes.
- R6: Every write strobe is low for exactly WR_CYC cycles. `bus_oe` rises one cycle before the strobe falls and drops one cycle after the strobe rises, so it is high for WR_CYC+2 cycles.
- R7: Command codes 4 (data read) and 5 (status read) each produce one read strobe that is low for RD_CYC cycles. The port byte from the last strobe cycle appears on `rd_data`, and `rd_valid` is high for exactly one cycle.
- R8: `busy` is high from the cycle after a command is taken until its recovery gap has ended. A one-byte access lasts strobe+2+GAP_CYC cycles and a two-byte sequence twice that. Commands offered while busy, and code 7 at any time, are ignored.
- R9: Command code 6 keeps `vdp_rst_n` high for RST_HI_CYC cycles, then low for RST_LO_CYC cycles, then releases it high. No strobe is asserted during this sequence.
- R10: After `rst_n`, both strobes are high, `bus_oe` and `busy` are low, and `vdp_rst_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Offers a command for one cycle |
| cmd_op | input | 3 | Command code (0 to 6) |
| cmd_arg | input | 14 | VRAM address, or register index in bits 2:0 |
| cmd_data | input | 8 | Value for a register write or data write |
| busy | output | 1 | A command is in progress |
| rd_data | output | 8 | Byte captured by the last read |
| rd_valid | output | 1 | One-cycle pulse when rd_data is updated |
| bus_mode | output | 1 | 1 = control port, 0 = data port |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_oe | output | 1 | Drive enable for the shared data bus |
| bus_dout | output | 8 | Byte to drive onto the port |
| bus_din | input | 8 | Byte read from the port |
| vdp_rst_n | output | 1 | Reset line to the display processor |

## Verification
The embedded assertions check, on every cycle, the properties that hold at any moment. The two strobes never overlap. The output enable covers the whole write strobe. Mode and byte stay steady while a strobe is low. No strobe runs longer than its limit. The read valid pulse lasts one cycle, and no strobe appears while the reset line is low or while the block is idle. Only the bench scenarios can show that the byte order and prefixes match each command, that exactly the expected number of accesses occurs, that busy lasts the right number of cycles and that ignored commands leave the port quiet. The same applies to the exact widths of the reset phases.

// File: rtl/vdp_seq_pkg.sv
package vdp_seq_pkg;
  localparam int ADDR_W = 14;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    OP_REG    = 3'd0,
    OP_WADDR  = 3'd1,
    OP_RADDR  = 3'd2,
    OP_WDATA  = 3'd3,
    OP_RDATA  = 3'd4,
    OP_STATUS = 3'd5,
    OP_RESET  = 3'd6
  } vdp_op_e;

  typedef enum logic [2:0] {E_IDLE, E_SETUP, E_STROBE, E_HOLD, E_GAP} eng_st_e;
  typedef enum logic [1:0] {S_IDLE, S_B0, S_B1, S_RST} seq_st_e;
  typedef enum logic [1:0] {RG_IDLE, RG_HI, RG_LO} rg_st_e;

  function automatic logic op_legal(input logic [2:0] op);
    return op != 3'd7;
  endfunction

  // Control-port ops drive mode high; data ops low.
  function automatic logic op_mode(input vdp_op_e op);
    return !(op == OP_WDATA || op == OP_RDATA);
  endfunction

  function automatic logic op_is_write(input vdp_op_e op);
    return !(op == OP_RDATA || op == OP_STATUS);
  endfunction

  function automatic logic op_two_byte(input vdp_op_e op);
    return op == OP_REG || op == OP_WADDR || op == OP_RADDR;
  endfunction

  function automatic logic [BYTE_W-1:0] ctl_first(input vdp_op_e op,
      input logic [ADDR_W-1:0] arg, input logic [BYTE_W-1:0] data);
    return (op == OP_REG || op == OP_WDATA) ? data : arg[7:0];
  endfunction

  function automatic logic [BYTE_W-1:0] ctl_second(input vdp_op_e op,
      input logic [ADDR_W-1:0] arg);
    case (op)
      OP_REG:   return {5'b10000, arg[2:0]};
      OP_WADDR: return {2'b01, arg[13:8]};
      default:  return {2'b00, arg[13:8]};
    endcase
  endfunction
endpackage

// File: rtl/vdp_byte_engine.sv
module vdp_byte_engine
  import vdp_seq_pkg::*;
#(
  parameter int WR_CYC  = 100,
  parameter int RD_CYC  = 80,
  parameter int GAP_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_wr,
  input  logic              start_mode,
  input  logic [BYTE_W-1:0] start_byte,
  input  logic [BYTE_W-1:0] din,
  output logic              done,
  output logic              wr_n,
  output logic              rd_n,
  output logic              oe,
  output logic              mode,
  output logic [BYTE_W-1:0] dout,
  output logic [BYTE_W-1:0] rdata,
  output logic              rvalid
);
  localparam int MAXS = (WR_CYC > RD_CYC) ? WR_CYC : RD_CYC;
  localparam int MAXC = (MAXS > GAP_CYC) ? MAXS : GAP_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] WR_LIM  = CW'(WR_CYC - 1);
  localparam logic [CW-1:0] RD_LIM  = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] GAP_LIM = CW'(GAP_CYC - 1);

  eng_st_e           st;
  logic [CW-1:0]     cnt;
  logic              wr_q;
  logic              strobe_last;

  assign strobe_last = (st == E_STROBE) && (cnt == (wr_q ? WR_LIM : RD_LIM));
  assign done = (st == E_GAP) && (cnt == GAP_LIM);
  assign wr_n = !((st == E_STROBE) && wr_q);
  assign rd_n = !((st == E_STROBE) && !wr_q);
  assign oe   = wr_q && (st == E_SETUP || st == E_STROBE || st == E_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= E_IDLE; cnt <= '0; wr_q <= 1'b0; mode <= 1'b1;
      dout <= '0; rdata <= '0; rvalid <= 1'b0;
    end else begin
      rvalid <= 1'b0;
      case (st)
        E_SETUP: begin st <= E_STROBE; cnt <= '0; end
        E_STROBE: begin
          if (strobe_last) begin
            st <= E_HOLD;
            if (!wr_q) begin rdata <= din; rvalid <= 1'b1; end
          end else cnt <= cnt + 1'b1;
        end
        E_HOLD: begin st <= E_GAP; cnt <= '0; end
        E_GAP: begin
          if (done) st <= E_IDLE;
          else cnt <= cnt + 1'b1;
        end
        default: ;
      endcase
      if (start) begin
        st <= E_SETUP; wr_q <= start_wr; mode <= start_mode; dout <= start_byte;
      end
    end
  end

  // Independent run-length counters for the strobe width checks
  logic [CW:0] wlow_run, rlow_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin wlow_run <= '0; rlow_run <= '0; end
    else begin
      wlow_run <= wr_n ? '0 : wlow_run + 1'b1;
      rlow_run <= rd_n ? '0 : rlow_run + 1'b1;
    end
  end

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_n || rd_n);
  // R6
  oe_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> oe);
  // R6
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe) |-> (wr_n && $past(wr_n)));
  // R6
  wr_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wlow_run <= (CW+1)'(WR_CYC));
  // R7
  rd_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rlow_run <= (CW+1)'(RD_CYC));
  // R1
  held_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n || !rd_n) |=> ((wr_n && rd_n) || ($stable(mode) && $stable(dout))));
endmodule

// File: rtl/vdp_reset_pulse.sv
module vdp_reset_pulse
  import vdp_seq_pkg::*;
#(
  parameter int HI_CYC = 1000,
  parameter int LO_CYC = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done,
  output logic rst_out_n
);
  localparam int MAXC = (HI_CYC > LO_CYC) ? HI_CYC : LO_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] HI_LIM = CW'(HI_CYC - 1);
  localparam logic [CW-1:0] LO_LIM = CW'(LO_CYC - 1);

  rg_st_e        st;
  logic [CW-1:0] cnt;

  assign rst_out_n = (st != RG_LO);
  assign done = (st == RG_LO) && (cnt == LO_LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin st <= RG_IDLE; cnt <= '0; end
    else begin
      case (st)
        RG_HI: if (cnt == HI_LIM) begin st <= RG_LO; cnt <= '0; end
               else cnt <= cnt + 1'b1;
        RG_LO: if (done) st <= RG_IDLE;
               else cnt <= cnt + 1'b1;
        default: ;
      endcase
      if (start) begin st <= RG_HI; cnt <= '0; end
    end
  end

  logic [CW:0] lo_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lo_run <= '0;
    else lo_run <= rst_out_n ? '0 : lo_run + 1'b1;
  end

  // R9
  lo_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_run <= (CW+1)'(LO_CYC));
endmodule

// File: rtl/vdp_host_seq.sv
module vdp_host_seq
  import vdp_seq_pkg::*;
#(
  parameter int WR_CYC     = 100,
  parameter int RD_CYC     = 80,
  parameter int GAP_CYC    = 4,
  parameter int RST_HI_CYC = 1000,
  parameter int RST_LO_CYC = 50
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [2:0]  cmd_op,
  input  logic [13:0] cmd_arg,
  input  logic [7:0]  cmd_data,
  output logic        busy,
  output logic [7:0]  rd_data,
  output logic        rd_valid,
  output logic        bus_mode,
  output logic        bus_wr_n,
  output logic        bus_rd_n,
  output logic        bus_oe,
  output logic [7:0]  bus_dout,
  input  logic [7:0]  bus_din,
  output logic        vdp_rst_n
);
  seq_st_e           st;
  vdp_op_e           op;
  logic              two_q;
  logic [BYTE_W-1:0] sec_q;
  logic              accept, eng_start, eng_done, rg_start, rg_done;
  logic              eng_wr, eng_mode;
  logic [BYTE_W-1:0] eng_byte;

  assign op       = vdp_op_e'(cmd_op);
  assign accept   = cmd_valid && (st == S_IDLE) && op_legal(cmd_op);
  assign rg_start = accept && (op == OP_RESET);
  assign eng_start = (accept && op != OP_RESET) || (st == S_B0 && eng_done && two_q);
  assign eng_byte = accept ? ctl_first(op, cmd_arg, cmd_data) : sec_q;
  assign eng_wr   = accept ? op_is_write(op) : 1'b1;
  assign eng_mode = accept ? op_mode(op) : 1'b1;
  assign busy     = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin st <= S_IDLE; two_q <= 1'b0; sec_q <= '0; end
    else begin
      case (st)
        S_IDLE: if (accept) begin
          if (op == OP_RESET) st <= S_RST;
          else begin
            st <= S_B0; two_q <= op_two_byte(op); sec_q <= ctl_second(op, cmd_arg);
          end
        end
        S_B0:  if (eng_done) st <= two_q ? S_B1 : S_IDLE;
        S_B1:  if (eng_done) st <= S_IDLE;
        S_RST: if (rg_done) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  vdp_byte_engine #(.WR_CYC(WR_CYC), .RD_CYC(RD_CYC), .GAP_CYC(GAP_CYC)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .start_wr(eng_wr),
    .start_mode(eng_mode), .start_byte(eng_byte), .din(bus_din), .done(eng_done),
    .wr_n(bus_wr_n), .rd_n(bus_rd_n), .oe(bus_oe), .mode(bus_mode),
    .dout(bus_dout), .rdata(rd_data), .rvalid(rd_valid));

  vdp_reset_pulse #(.HI_CYC(RST_HI_CYC), .LO_CYC(RST_LO_CYC)) u_rst (
    .clk(clk), .rst_n(rst_n), .start(rg_start), .done(rg_done), .rst_out_n(vdp_rst_n));

  // R7
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (bus_wr_n && bus_rd_n && !bus_oe));
  // R9
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vdp_rst_n |-> (bus_wr_n && bus_rd_n));
  // R4
  second_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_B1 && !bus_wr_n) |-> bus_mode);
endmodule

// File: tb/sim_vdp_host_seq.sv
module sim_vdp_host_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WR = 4, RD = 3, GAP = 2, RHI = 12, RLO = 5;

  logic clk = 0, rst_n = 0, cmd_valid = 0;
  logic [2:0] cmd_op = 0;
  logic [13:0] cmd_arg = 0;
  logic [7:0] cmd_data = 0, bus_din = 0;
  logic busy, rd_valid, bus_mode, bus_wr_n, bus_rd_n, bus_oe, vdp_rst_n;
  logic [7:0] rd_data, bus_dout;

  always #(CLK_PERIOD/2) clk = ~clk;

  vdp_host_seq #(.WR_CYC(WR), .RD_CYC(RD), .GAP_CYC(GAP), .RST_HI_CYC(RHI),
    .RST_LO_CYC(RLO)) u0 (.*);

  int checks = 0, errors = 0, mchecks = 0, merrors = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Port monitor
  int log_n = 0, rd_cnt = 0, rdv_cnt = 0, wr_run = 0, oe_run = 0, rd_run = 0;
  logic [7:0] log_byte [64];
  logic log_mode [64];
  logic rd_mode_last = 0, first_ok = 0, pwr = 1, prd = 1, poe = 0;
  logic [7:0] rdv_data = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!bus_wr_n && !bus_rd_n) begin
        mchecks++; merrors++;
        $display("FAIL R2 overlap: actual 0 expected 1");
      end
      if (!bus_wr_n && pwr) begin
        log_byte[log_n % 64] = bus_dout; log_mode[log_n % 64] = bus_mode; log_n++;
      end
      if (!bus_wr_n) wr_run++;
      if (bus_oe) begin
        if (!poe) first_ok = bus_wr_n;
        oe_run++;
      end
      if (!bus_oe && poe) begin
        mchecks++;
        if (oe_run != WR + 2 || wr_run != WR || !first_ok || !pwr) begin
          merrors++;
          $display("FAIL R6 oe/strobe: actual %0d/%0d expected %0d/%0d",
                   oe_run, wr_run, WR + 2, WR);
        end
        oe_run = 0; wr_run = 0;
      end
      if (!bus_rd_n) rd_run++;
      if (!bus_rd_n && prd) begin rd_cnt++; rd_mode_last = bus_mode; end
      if (bus_rd_n && !prd) begin
        mchecks++;
        if (rd_run != RD) begin
          merrors++;
          $display("FAIL R7 read width: actual %0d expected %0d", rd_run, RD);
        end
        rd_run = 0;
      end
      if (rd_valid) begin rdv_cnt++; rdv_data = rd_data; end
    end
    pwr = bus_wr_n; prd = bus_rd_n; poe = bus_oe;
  end

  function automatic logic [7:0] exp_second(input int op, input int arg);
    if (op == 0) return 8'(128 + (arg % 8));
    if (op == 1) return 8'(64 + arg / 256);
    return 8'(arg / 256);
  endfunction

  int busy_len, hi_cnt, lo_cnt;
  bit rst_order_bad, rst_strobe;

  task automatic issue(input int op, input int arg, input int data);
    int guard;
    guard = 0;
    while (busy && guard < 5000) begin @(negedge clk); guard++; end
    cmd_valid = 1; cmd_op = 3'(op); cmd_arg = 14'(arg); cmd_data = 8'(data);
    @(negedge clk);
    cmd_valid = 0;
    busy_len = 0; hi_cnt = 0; lo_cnt = 0; rst_order_bad = 0; rst_strobe = 0;
    while (busy && guard < 5000) begin
      busy_len++;
      if (vdp_rst_n) begin hi_cnt++; if (lo_cnt != 0) rst_order_bad = 1; end
      else lo_cnt++;
      if (op == 6 && (!bus_wr_n || !bus_rd_n)) rst_strobe = 1;
      @(negedge clk); guard++;
    end
  endtask

  task automatic run_cmd(input int op, input int arg, input int data, input int din);
    int l0, r0, v0, a;
    a = arg & 16'h3fff;
    bus_din = 8'(din);
    l0 = log_n; r0 = rd_cnt; v0 = rdv_cnt;
    issue(op, a, data);
    if (op <= 2) begin
      chk(log_n == l0 + 2 && rd_cnt == r0, "R3/R4", "write count", log_n - l0, 2);
      chk(log_mode[l0 % 64] && log_mode[(l0 + 1) % 64], "R1", "ctl mode", 0, 1);
      chk(log_byte[l0 % 64] == ((op == 0) ? 8'(data) : 8'(a % 256)),
          (op == 0) ? "R3" : "R4", "first byte", log_byte[l0 % 64],
          (op == 0) ? data & 255 : a % 256);
      chk(log_byte[(l0 + 1) % 64] == exp_second(op, a), (op == 0) ? "R3" : "R4",
          "second byte", log_byte[(l0 + 1) % 64], exp_second(op, a));
      chk(busy_len == 2 * (WR + 2 + GAP), "R8", "busy len", busy_len, 2 * (WR + 2 + GAP));
    end else if (op == 3) begin
      chk(log_n == l0 + 1 && rd_cnt == r0, "R5", "write count", log_n - l0, 1);
      chk(!log_mode[l0 % 64], "R1", "data mode", 1, 0);
      chk(log_byte[l0 % 64] == 8'(data), "R5", "data byte", log_byte[l0 % 64], data & 255);
      chk(busy_len == WR + 2 + GAP, "R8", "busy len", busy_len, WR + 2 + GAP);
    end else begin
      chk(rd_cnt == r0 + 1 && log_n == l0, "R7", "read count", rd_cnt - r0, 1);
      chk(rd_mode_last == (op == 5), "R1", "read mode", rd_mode_last, op == 5);
      chk(rdv_cnt == v0 + 1, "R7", "valid pulses", rdv_cnt - v0, 1);
      chk(rdv_data == 8'(din), "R7", "read data", rdv_data, din & 255);
      chk(busy_len == RD + 2 + GAP, "R8", "busy len", busy_len, RD + 2 + GAP);
    end
  endtask

  initial begin
    int l0;
    void'($urandom(32'd1234));
    #(CLK_PERIOD * 3);
    @(negedge clk);
    // R10 reset state
    chk(bus_wr_n && bus_rd_n && !bus_oe && !busy && vdp_rst_n, "R10", "reset outputs",
        {bus_wr_n, bus_rd_n, bus_oe, busy, vdp_rst_n}, 5'b11001);
    rst_n = 1;
    @(negedge clk);
    chk(bus_wr_n && bus_rd_n && !busy, "R2", "idle strobes", {bus_wr_n, bus_rd_n}, 3);

    // Directed corners
    run_cmd(0, 7, 8'hA5, 0);
    run_cmd(0, 0, 8'h00, 0);
    run_cmd(1, 14'h3FFF, 0, 0);
    run_cmd(2, 14'h3FFF, 0, 0);
    run_cmd(1, 14'h0000, 0, 0);
    run_cmd(3, 0, 8'hFF, 0);
    run_cmd(4, 0, 0, 8'h5A);
    run_cmd(5, 0, 0, 8'hC3);

    // R8 command offered while busy is ignored
    l0 = log_n;
    bus_din = 0;
    cmd_valid = 1; cmd_op = 0; cmd_arg = 3; cmd_data = 8'h11;
    @(negedge clk);
    cmd_op = 3; cmd_data = 8'h22;
    @(negedge clk);
    cmd_valid = 0;
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(log_n == l0 + 2, "R8", "writes with busy cmd", log_n - l0, 2);
    chk(log_byte[(l0 + 1) % 64] == 8'h83, "R8", "second byte", log_byte[(l0 + 1) % 64], 8'h83);

    // R8 code 7 ignored
    l0 = log_n;
    cmd_valid = 1; cmd_op = 7;
    @(negedge clk);
    cmd_valid = 0;
    chk(!busy, "R8", "code 7 busy", busy, 0);
    repeat (4) @(negedge clk);
    chk(log_n == l0 && bus_rd_n && bus_wr_n, "R8", "code 7 port", log_n - l0, 0);

    // R9 reset pulse
    l0 = log_n;
    issue(6, 0, 0);
    chk(hi_cnt == RHI, "R9", "high phase", hi_cnt, RHI);
    chk(lo_cnt == RLO, "R9", "low phase", lo_cnt, RLO);
    chk(!rst_order_bad && vdp_rst_n, "R9", "order/release", rst_order_bad, 0);
    chk(!rst_strobe && log_n == l0, "R9", "no strobe", rst_strobe, 0);

    // Random mix
    for (int i = 0; i < 40; i++) begin
      int op;
      op = int'($urandom % 6);
      run_cmd(op, int'($urandom), int'($urandom % 256), int'($urandom % 256));
    end

    repeat (5) @(negedge clk);
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks + mchecks, errors + merrors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done_flag) begin
      done_flag = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks + mchecks + 1, errors + merrors);
      $finish;
    end
  end
endmodule